// File: doc/BRIEF.md
# Message-Interrupt Best-Candidate Scanner

This block walks the range of message-signalled interrupt IDs that belong to one processor and picks the best one that is both pending and enabled. Pending state lives in an external bitmap, one bit per ID, read a byte at a time through a simple read port with a fixed one-cycle latency. Per-ID configuration bytes, holding a priority and an enable flag, sit in a small store inside the block that is written through a byte write port.

A scan starts when the pending bitmap is reported as changed or when a configuration byte is written. At that moment the block samples an incumbent, meaning the best candidate already found among the other interrupt sources, given as ID, priority and group. The scan merges every qualifying message interrupt against that incumbent. When it finishes, the block pulses `done` and presents the surviving ID, priority and group, together with a flag that says whether a message interrupt displaced the incumbent. A new start event during a scan throws away the partial result and begins again at the lowest ID.

Top module: `lpi_best_pick`

## Requirements
- R1: The scan covers IDs BASE_ID to BASE_ID+NUM_LPI-1 (8192 to 8255 by default). The pending bit of ID n is bit n%8 of bitmap byte n/8, so the byte addresses are 1024 to 1031, issued in ascending order. Read data is sampled the cycle after `pend_rd_en`.
- R2: Configuration byte k (index = ID - BASE_ID) carries a 6-bit priority field in bits [7:2] and the enable flag in bit 0. The reported priority is the field followed by two zero bits. Bit 1 has no effect.
- R3: A message interrupt qualifies only when its pending bit is 1, its enable bit is 1 and `grp1ns_en` is 1.
- R4: When a message interrupt wins, `best_grp` reads 2, the code for non-secure group 1.
- R5: A candidate displaces the current best when its priority value is numerically lower, or when the priorities are equal and its ID is lower. The same rule decides between message interrupts.
- R6: When nothing displaces the incumbent, the outputs equal the incumbent sampled at the start event and `new_win` is 0. An idle incumbent (priority 0xFF) loses to any qualifying message interrupt.
- R7: A start event is `pend_chg`=1 or `cfg_we`=1 at a clock edge. The incumbent inputs are sampled at that edge. A start event during a scan restarts it from the lowest ID, and only the restarted scan reports.
- R8: `done` is a one-cycle pulse. It appears 2*NUM_LPI/8 cycles after the start edge (16 by default), because each byte costs a fetch cycle and an evaluation cycle. The result outputs change only together with `done`.
- R9: During and after reset, `done`, `pend_rd_en` and `new_win` are 0, `best_id` is 0 and `best_prio` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_chg | input | 1 | Pending bitmap changed; starts a scan |
| cfg_we | input | 1 | Configuration byte write strobe; also starts a scan |
| cfg_idx | input | $clog2(NUM_LPI) | Configuration entry index (ID - BASE_ID) |
| cfg_data | input | 8 | Configuration byte: priority [7:2], enable [0] |
| grp1ns_en | input | 1 | Non-secure group 1 enabled |
| inc_id | input | ID_W | Incumbent ID |
| inc_prio | input | 8 | Incumbent priority (0xFF = none) |
| inc_grp | input | 2 | Incumbent group code |
| pend_rd_en | output | 1 | Pending bitmap byte read request |
| pend_rd_addr | output | ID_W-3 | Pending bitmap byte address (ID/8) |
| pend_rd_data | input | 8 | Pending bitmap byte, valid the cycle after the request |
| done | output | 1 | Scan finished; result outputs updated |
| best_id | output | ID_W | Winning ID |
| best_prio | output | 8 | Winning priority |
| best_grp | output | 2 | Winning group code |
| new_win | output | 1 | A message interrupt displaced the incumbent |

## Verification
A byte counter that slips or a stuck fetch/evaluate state shows up at the ports on the very next request. The read address breaks its ascending sequence, and `done` misses its fixed 16-cycle slot after the start event. A running best that was not reloaded from the incumbent, or that applies the tie-break the wrong way round, is only seen when `done` pulses. It then shows as a wrong ID, priority or `new_win`, which is why the vectors use equal-priority pairs and incumbents that sit on both sides of the winning ID. A restart that fails to discard partial state reports a winner that is no longer pending.

// File: rtl/lpi_best_pick.sv
module lpi_best_pick #(
  parameter int NUM_LPI = 64,
  parameter int ID_W    = 16,
  parameter int BASE_ID = 8192,
  parameter int G1NS    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pend_chg,
  input  logic                       cfg_we,
  input  logic [$clog2(NUM_LPI)-1:0] cfg_idx,
  input  logic [7:0]                 cfg_data,
  input  logic                       grp1ns_en,
  input  logic [ID_W-1:0]            inc_id,
  input  logic [7:0]                 inc_prio,
  input  logic [1:0]                 inc_grp,
  output logic                       pend_rd_en,
  output logic [ID_W-4:0]            pend_rd_addr,
  input  logic [7:0]                 pend_rd_data,
  output logic                       done,
  output logic [ID_W-1:0]            best_id,
  output logic [7:0]                 best_prio,
  output logic [1:0]                 best_grp,
  output logic                       new_win
);
  localparam int NB = NUM_LPI / 8;
  localparam int BW = $clog2(NB);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EVAL} st_t;

  logic [7:0]      cfg [NUM_LPI];
  st_t             st;
  logic [BW-1:0]   byte_q;
  logic [ID_W-1:0] run_id;
  logic [7:0]      run_prio;
  logic [1:0]      run_grp;
  logic            run_new;

  logic            c_hit;
  logic [7:0]      c_prio;
  logic [2:0]      c_off;
  logic [ID_W-1:0] cand_id;
  logic            take;

  wire trig = pend_chg | cfg_we;
  wire last = byte_q == BW'(NB - 1);

  always_ff @(posedge clk)
    if (cfg_we) cfg[cfg_idx] <= cfg_data;

  always_comb begin
    c_hit  = 1'b0;
    c_prio = 8'hFF;
    c_off  = '0;
    for (int j = 0; j < 8; j++) begin
      logic [7:0] e;
      logic [7:0] p;
      e = cfg[{byte_q, 3'(j)}];
      p = {e[7:2], 2'b00};
      if (pend_rd_data[j] && e[0] && grp1ns_en && (!c_hit || p < c_prio)) begin
        c_hit  = 1'b1;
        c_prio = p;
        c_off  = 3'(j);
      end
    end
  end

  assign cand_id = ID_W'(BASE_ID) + ID_W'({byte_q, c_off});
  assign take    = c_hit && (c_prio < run_prio ||
                             (c_prio == run_prio && cand_id < run_id));

  assign pend_rd_en   = st == S_FETCH;
  assign pend_rd_addr = (ID_W-3)'(BASE_ID / 8) + (ID_W-3)'(byte_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      byte_q    <= '0;
      run_id    <= '0;
      run_prio  <= 8'hFF;
      run_grp   <= '0;
      run_new   <= 1'b0;
      done      <= 1'b0;
      best_id   <= '0;
      best_prio <= 8'hFF;
      best_grp  <= '0;
      new_win   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (trig) begin
        st       <= S_FETCH;
        byte_q   <= '0;
        run_id   <= inc_id;
        run_prio <= inc_prio;
        run_grp  <= inc_grp;
        run_new  <= 1'b0;
      end else begin
        case (st)
          S_FETCH: st <= S_EVAL;
          S_EVAL: begin
            if (take) begin
              run_id   <= cand_id;
              run_prio <= c_prio;
              run_grp  <= 2'(G1NS);
              run_new  <= 1'b1;
            end
            if (last) begin
              st        <= S_IDLE;
              done      <= 1'b1;
              best_id   <= take ? cand_id : run_id;
              best_prio <= take ? c_prio : run_prio;
              best_grp  <= take ? 2'(G1NS) : run_grp;
              new_win   <= run_new | take;
            end else begin
              byte_q <= byte_q + 1'b1;
              st     <= S_FETCH;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lpi_best_pick_chk.sv
module lpi_best_pick_chk #(
  parameter int NUM_LPI = 64,
  parameter int ID_W    = 16,
  parameter int BASE_ID = 8192,
  parameter int G1NS    = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pend_chg,
  input logic            cfg_we,
  input logic            pend_rd_en,
  input logic [ID_W-4:0] pend_rd_addr,
  input logic            done,
  input logic [ID_W-1:0] best_id,
  input logic [7:0]      best_prio,
  input logic [1:0]      best_grp,
  input logic            new_win
);
  localparam int LO_B = BASE_ID / 8;
  localparam int HI_B = LO_B + NUM_LPI / 8;

  p_addr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rd_en |-> (int'(pend_rd_addr) >= LO_B && int'(pend_rd_addr) < HI_B));

  p_win_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && new_win) |-> (int'(best_id) >= BASE_ID && int'(best_id) < BASE_ID + NUM_LPI));

  p_prio_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && new_win) |-> best_prio[1:0] == 2'b00);

  p_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && new_win) |-> best_grp == 2'(G1NS));

  p_fetch_eval_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rd_en && !pend_chg && !cfg_we) |=> !pend_rd_en);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(best_id) || !$stable(best_prio) || !$stable(new_win)) |-> done);
endmodule

bind lpi_best_pick lpi_best_pick_chk #(
  .NUM_LPI(NUM_LPI), .ID_W(ID_W), .BASE_ID(BASE_ID), .G1NS(G1NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_chg(pend_chg), .cfg_we(cfg_we),
  .pend_rd_en(pend_rd_en), .pend_rd_addr(pend_rd_addr), .done(done),
  .best_id(best_id), .best_prio(best_prio), .best_grp(best_grp),
  .new_win(new_win)
);

// File: tb/sim_lpi_best_pick.sv
`timescale 1ns/1ps
module sim_lpi_best_pick;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pend_chg = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [7:0]  cfg_data = '0;
  logic        grp1ns_en = 1'b1;
  logic [15:0] inc_id = '0;
  logic [7:0]  inc_prio = 8'hFF;
  logic [1:0]  inc_grp = '0;
  logic        pend_rd_en;
  logic [12:0] pend_rd_addr;
  logic [7:0]  pend_rd_data = '0;
  logic        done;
  logic [15:0] best_id;
  logic [7:0]  best_prio;
  logic [1:0]  best_grp;
  logic        new_win;

  logic [7:0]  pmem [8];
  int          n_chk = 0;
  int          n_bad = 0;
  int          rd_cnt = 0;
  int          rd_err = 0;
  int          lat;

  always #2.5 clk = ~clk;

  lpi_best_pick u0 (.*);

  always_ff @(posedge clk) begin
    if (pend_rd_en) begin
      pend_rd_data <= pmem[3'(pend_rd_addr - 13'd1024)];
      if (int'(pend_rd_addr) != 1024 + (rd_cnt % 8)) rd_err <= rd_err + 1;
      rd_cnt <= rd_cnt + 1;
    end
  end

  typedef struct packed {
    logic [63:0] mask;
    logic [15:0] iid;
    logic [7:0]  ip;
    logic [15:0] eid;
    logic [7:0]  ep;
    logic        en;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{64'h0,                 16'd100,  8'hFF, 16'd100,  8'hFF, 1'b0},
    '{64'h400,               16'd0,    8'hFF, 16'd8202, 8'hA0, 1'b1},
    '{64'h408,               16'd0,    8'hFF, 16'd8195, 8'h28, 1'b1},
    '{64'h100008,            16'd0,    8'hFF, 16'd8195, 8'h28, 1'b1},
    '{64'h20,                16'd48,   8'hFF, 16'd48,   8'hFF, 1'b0},
    '{64'h8000000000000008,  16'd0,    8'hFF, 16'd8255, 8'h04, 1'b1},
    '{64'h100000,            16'd40,   8'h28, 16'd40,   8'h28, 1'b0},
    '{64'h8,                 16'd9000, 8'h28, 16'd8195, 8'h28, 1'b1},
    '{64'h400,               16'd50,   8'h10, 16'd50,   8'h10, 1'b0},
    '{64'h81,                16'd0,    8'hFF, 16'd8192, 8'hA0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mem(input logic [63:0] m);
    for (int b = 0; b < 8; b++) pmem[b] = m[b*8 +: 8];
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual no done expected done");
    end
  endtask

  task automatic kick(input logic [15:0] iid, input logic [7:0] ip);
    inc_id = iid;
    inc_prio = ip;
    rd_cnt = 0;
    rd_err = 0;
    pend_chg = 1'b1;
    @(negedge clk);
    pend_chg = 1'b0;
  endtask

  task automatic wr_cfg(input int idx, input logic [7:0] d);
    cfg_idx = 6'(idx);
    cfg_data = d;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_res(input string req, input logic [15:0] eid,
                           input logic [7:0] ep, input logic en, input logic [1:0] eg);
    chk({req, " id"}, 32'(best_id), 32'(eid));
    chk({req, " prio"}, 32'(best_prio), 32'(ep));
    chk({req, " new_win"}, 32'(new_win), 32'(en));
    chk("R4 group", 32'(best_grp), 32'(eg));
  endtask

  initial begin
    set_mem(64'h0);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 done", 32'(done), 0);
    chk("R9 rd_en", 32'(pend_rd_en), 0);
    chk("R9 best_prio", 32'(best_prio), 32'hFF);
    chk("R9 best_id", 32'(best_id), 0);
    chk("R9 new_win", 32'(new_win), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 configuration: field 40 enabled everywhere, then specials
    for (int k = 0; k < 64; k++) wr_cfg(k, 8'hA3);
    wr_cfg(3, 8'h2B);
    wr_cfg(5, 8'h0A);
    wr_cfg(20, 8'h29);   // R2: bit 1 clear, same priority as LPI 3
    wr_cfg(63, 8'h07);
    wait_done(lat);

    // Table walk: R1 R2 R3 R5 R6 R8
    for (int v = 0; v < 10; v++) begin
      set_mem(VEC[v].mask);
      kick(VEC[v].iid, VEC[v].ip);
      wait_done(lat);
      check_res($sformatf("R5/R6 vec%0d", v), VEC[v].eid, VEC[v].ep, VEC[v].en,
                VEC[v].en ? 2'd2 : 2'd0);
      chk("R8 latency", 32'(lat), 16);
      chk("R1 read count", 32'(rd_cnt), 8);
      chk("R1 read order", 32'(rd_err), 0);
      @(negedge clk);
      chk("R8 done pulse", 32'(done), 0);
    end

    // R3: group disabled blocks a pending, enabled LPI
    grp1ns_en = 1'b0;
    set_mem(64'h8000000000000000);
    kick(16'd77, 8'hFF);
    wait_done(lat);
    check_res("R3 group off", 16'd77, 8'hFF, 1'b0, 2'd0);
    grp1ns_en = 1'b1;

    // R7: restart mid-scan discards old pending and incumbent
    set_mem(64'h400);
    kick(16'd0, 8'hFF);
    repeat (4) @(negedge clk);
    chk("R7 no early done", 32'(done), 0);
    set_mem(64'h8000000000000000);
    inc_grp = 2'd1;
    kick(16'd1, 8'hFF);
    wait_done(lat);
    check_res("R7 restart", 16'd8255, 8'h04, 1'b1, 2'd2);
    chk("R7 restart latency", 32'(lat), 16);

    // R7: configuration write starts a scan; R6 incumbent group kept
    set_mem(64'h8);
    inc_id = 16'd5;
    inc_prio = 8'hFF;
    wr_cfg(3, 8'h0A);
    wait_done(lat);
    check_res("R7 cfg trigger", 16'd5, 8'hFF, 1'b0, 2'd1);
    chk("R7 cfg latency", 32'(lat), 16);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule